// File: doc/BRIEF.md
# Bit-Parallel NFA Matching Engine

This block runs a small nondeterministic finite automaton over a byte stream and takes one byte per clock cycle. Every state owns one column of a symbol-match memory that has one row for each possible byte value. When a byte is accepted, its row is read out, so every state learns in a single access whether it accepts that byte. The row is masked with the set of states that are currently enabled. The states that are left have matched. A full state-to-state connection matrix turns the matched states into the enabled set for the following byte. Any number of states can be active at the same time.

Each state also carries a start setting and a report flag. The start setting is one of: never self-enabled, enabled only for the first byte of a stream, or enabled for every byte. When a state with its report flag set matches, its bit rises in a report vector during the cycle after the byte. A register holds the zero-based position of that byte within the stream.

Configuration writes come in three kinds: one state's whole match column, one row of the connection matrix, or one state's attributes. The engine takes a write only when no byte is being presented. Because the match columns and the connections are written separately, new patterns can be loaded into an existing automaton structure without rewriting its routing.

Top module: `nfa_engine`

## Requirements
- R1: After reset, reportVec is all zero, reportValid is 0 and reportOffset is 0. Every match column, connection row and attribute is cleared, and the first byte of the stream counts as start-of-data.
- R2: A byte is accepted on a clock edge where symValid=1 and streamRst=0. State i matches that byte b when i is enabled for it and bit b of i's match column is 1. In the cycle after the edge, reportVec[i] is 1 exactly when state i matched and its report flag is set.
- R3: A state whose start setting is 2 (every byte) is enabled for every accepted byte, whatever happened before.
- R4: A state whose start setting is 1 (start-of-data) is enabled by that setting only for the first byte accepted after reset or after a stream reset. Start setting 0 or 3 never enables a state.
- R5: If state i matches a byte, every state j with bit j of i's connection row set is enabled for the next accepted byte. States with no matching predecessor are not enabled for that byte, and several states can be active together.
- R6: A state whose report flag is clear never sets its reportVec bit, but its matches are still routed.
- R7: reportOffset holds the zero-based position, counted since the last reset or stream reset, of the most recently accepted byte. reportValid is 1 exactly when reportVec is non-zero.
- R8: streamRst=1 clears the enabled set and the position counter, sets reportVec and reportOffset to 0 in the next cycle, and re-arms start-of-data. A byte presented in the same cycle is dropped.
- R9: A configuration write presented while symValid=1 is ignored.
- R10: cfgSel=0 writes cfgData[b] into bit b of state cfgState's match column. cfgSel=1 writes cfgData[STATES-1:0] as state cfgState's connection row, with bit j meaning "to state j". cfgSel=2 writes the start setting from cfgData[1:0] and the report flag from cfgData[2]. Rewriting a match column leaves the connections unchanged.
- R11: A cycle with no accepted byte leaves the enabled set unchanged and gives an all-zero reportVec in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| streamRst | input | 1 | Start a new stream: clear enabled set and position |
| symValid | input | 1 | A byte is presented on symData |
| symData | input | SYM_W | Input byte |
| cfgWrite | input | 1 | Configuration write strobe, taken only when symValid is 0 |
| cfgSel | input | 2 | Write kind: 0 match column, 1 connection row, 2 attributes |
| cfgState | input | $clog2(STATES) | State addressed by the write |
| cfgData | input | 2**SYM_W | Column bits, connection row, or attribute bits |
| reportValid | output | 1 | Some reporting state matched the previous byte |
| reportVec | output | STATES | One bit per reporting state that matched |
| reportOffset | output | OFF_W | Stream position of the last accepted byte |

## Verification
The bench builds the engine with its default parameters: 32 states, 8-bit bytes (a 256-row match memory) and a 16-bit position counter. With these values, directed chains such as a three-state "abc" path, start-of-data and every-byte states, idle gaps inside a pattern, and writes that collide with a byte can all sit side by side in one automaton. A randomly filled 32-state automaton with a dense connection matrix then keeps many states active together, and many matches meet stream resets at arbitrary positions.

// File: rtl/nfa_pkg.sv
package nfa_pkg;

  typedef enum logic [1:0] {
    CFG_COLUMN = 2'd0,
    CFG_ROUTE  = 2'd1,
    CFG_ATTR   = 2'd2,
    CFG_NONE   = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    START_NONE  = 2'd0,
    START_FIRST = 2'd1,
    START_EVERY = 2'd2,
    START_RSVD  = 2'd3
  } start_e;

  // strobes from control to datapath
  typedef struct packed {
    logic colWe;
    logic routeWe;
    logic attrWe;
    logic step;
    logic clear;
    logic first;
  } strobe_t;

endpackage

// File: rtl/nfa_ctrl.sv
module nfa_ctrl
  import nfa_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             streamRst,
  input  logic             symValid,
  input  logic             cfgWrite,
  input  logic [1:0]       cfgSel,
  output strobe_t          strb,
  output logic [OFF_W-1:0] reportOffset
);

  cfg_sel_e          sel;
  logic              idle;
  logic              firstPending;
  logic [OFF_W-1:0]  offset;

  assign sel  = cfg_sel_e'(cfgSel);
  assign idle = !symValid;

  always_comb begin
    strb         = '0;
    strb.colWe   = cfgWrite && idle && (sel == CFG_COLUMN);
    strb.routeWe = cfgWrite && idle && (sel == CFG_ROUTE);
    strb.attrWe  = cfgWrite && idle && (sel == CFG_ATTR);
    strb.clear   = streamRst;
    strb.step    = symValid && !streamRst;
    strb.first   = firstPending;
  end

  // stream position and start-of-data tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offset       <= '0;
      reportOffset <= '0;
      firstPending <= 1'b1;
    end else if (streamRst) begin
      offset       <= '0;
      reportOffset <= '0;
      firstPending <= 1'b1;
    end else if (symValid) begin
      reportOffset <= offset;
      offset       <= offset + 1'b1;
      firstPending <= 1'b0;
    end
  end

endmodule

// File: rtl/nfa_datapath.sv
module nfa_datapath
  import nfa_pkg::*;
#(
  parameter  int STATES = 32,
  parameter  int SYM_W  = 8,
  parameter  int SIDX_W = 5,
  localparam int ROWS   = 1 << SYM_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [SYM_W-1:0]  symData,
  input  logic [SIDX_W-1:0] cfgState,
  input  logic [ROWS-1:0]   cfgData,
  output logic [STATES-1:0] reportVec
);

  logic [STATES-1:0] matchMem [ROWS];
  logic [STATES-1:0] fanOut   [STATES];
  logic [STATES-1:0] enabled;
  logic [STATES-1:0] everyMask;
  logic [STATES-1:0] firstMask;
  logic [STATES-1:0] reportMask;
  logic [STATES-1:0] rowBits;
  logic [STATES-1:0] curEn;
  logic [STATES-1:0] matchVec;
  logic [STATES-1:0] nextEn;
  logic              stateOk;

  assign stateOk = (int'(cfgState) < STATES);

  // symbol-match memory: one row per byte value, one column per state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) matchMem[r] <= '0;
    end else if (strb.colWe && stateOk) begin
      for (int r = 0; r < ROWS; r++) matchMem[r][cfgState] <= cfgData[r];
    end
  end

  assign rowBits  = matchMem[symData];
  assign curEn    = enabled | everyMask | (strb.first ? firstMask : '0);
  assign matchVec = rowBits & curEn;

  // per-state attributes and connection rows
  for (genvar s = 0; s < STATES; s++) begin : g_state
    start_e            startMode;
    logic              repFlag;
    logic [STATES-1:0] routeRow;
    logic              hit;

    assign hit = (cfgState == SIDX_W'(s));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        startMode <= START_NONE;
        repFlag   <= 1'b0;
        routeRow  <= '0;
      end else begin
        if (strb.attrWe && hit) begin
          startMode <= start_e'(cfgData[1:0]);
          repFlag   <= cfgData[2];
        end
        if (strb.routeWe && hit) routeRow <= cfgData[STATES-1:0];
      end
    end

    assign everyMask[s]  = (startMode == START_EVERY);
    assign firstMask[s]  = (startMode == START_FIRST);
    assign reportMask[s] = repFlag;
    assign fanOut[s]     = matchVec[s] ? routeRow : '0;
  end

  // connection matrix: OR of rows of all matched states
  always_comb begin
    nextEn = '0;
    for (int i = 0; i < STATES; i++) nextEn |= fanOut[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabled   <= '0;
      reportVec <= '0;
    end else if (strb.clear) begin
      enabled   <= '0;
      reportVec <= '0;
    end else if (strb.step) begin
      enabled   <= nextEn;
      reportVec <= matchVec & reportMask;
    end else begin
      reportVec <= '0;
    end
  end

endmodule

// File: rtl/nfa_engine.sv
module nfa_engine
  import nfa_pkg::*;
#(
  parameter  int STATES = 32,
  parameter  int SYM_W  = 8,
  parameter  int OFF_W  = 16,
  localparam int SIDX_W = (STATES > 1) ? $clog2(STATES) : 1,
  localparam int ROWS   = 1 << SYM_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              streamRst,
  input  logic              symValid,
  input  logic [SYM_W-1:0]  symData,
  input  logic              cfgWrite,
  input  logic [1:0]        cfgSel,
  input  logic [SIDX_W-1:0] cfgState,
  input  logic [ROWS-1:0]   cfgData,
  output logic              reportValid,
  output logic [STATES-1:0] reportVec,
  output logic [OFF_W-1:0]  reportOffset
);

  strobe_t strb;

  nfa_ctrl #(.OFF_W(OFF_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .streamRst    (streamRst),
    .symValid     (symValid),
    .cfgWrite     (cfgWrite),
    .cfgSel       (cfgSel),
    .strb         (strb),
    .reportOffset (reportOffset)
  );

  nfa_datapath #(.STATES(STATES), .SYM_W(SYM_W), .SIDX_W(SIDX_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .symData   (symData),
    .cfgState  (cfgState),
    .cfgData   (cfgData),
    .reportVec (reportVec)
  );

  assign reportValid = |reportVec;

endmodule

// File: rtl/nfa_engine_chk.sv
module nfa_engine_chk #(
  parameter int STATES = 32,
  parameter int OFF_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              streamRst,
  input logic              symValid,
  input logic              reportValid,
  input logic [STATES-1:0] reportVec,
  input logic [OFF_W-1:0]  reportOffset
);

  // R11: no accepted byte, no report afterwards
  a_r11_idle_no_report: assert property (@(posedge clk) disable iff (!rstN)
    !symValid |=> (reportVec == '0));

  // R8: stream reset clears reports and position
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    streamRst |=> (reportVec == '0 && reportOffset == '0));

  // R7: first byte after a stream reset sits at position zero
  a_r7_first_zero: assert property (@(posedge clk) disable iff (!rstN)
    streamRst ##1 (symValid && !streamRst) |=> (reportOffset == '0));

  // R7: back-to-back bytes advance the position by one
  a_r7_offset_step: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && !streamRst) ##1 (symValid && !streamRst)
      |=> (reportOffset == OFF_W'($past(reportOffset) + 1'b1)));

  // R2: a report only follows an accepted byte
  a_r2_report_needs_byte: assert property (@(posedge clk) disable iff (!rstN)
    reportValid |-> $past(symValid && !streamRst));

endmodule

bind nfa_engine nfa_engine_chk #(.STATES(STATES), .OFF_W(OFF_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .streamRst    (streamRst),
  .symValid     (symValid),
  .reportValid  (reportValid),
  .reportVec    (reportVec),
  .reportOffset (reportOffset)
);

// File: tb/nfa_engine_test.sv
module nfa_engine_test;

  localparam int STATES = 32;
  localparam int SYM_W  = 8;
  localparam int OFF_W  = 16;
  localparam int SIDX_W = 5;
  localparam int ROWS   = 256;

  logic              clk;
  logic              rstN;
  logic              streamRst;
  logic              symValid;
  logic [SYM_W-1:0]  symData;
  logic              cfgWrite;
  logic [1:0]        cfgSel;
  logic [SIDX_W-1:0] cfgState;
  logic [ROWS-1:0]   cfgData;
  logic              reportValid;
  logic [STATES-1:0] reportVec;
  logic [OFF_W-1:0]  reportOffset;

  nfa_engine #(.STATES(STATES), .SYM_W(SYM_W), .OFF_W(OFF_W)) uut (
    .clk(clk), .rstN(rstN), .streamRst(streamRst), .symValid(symValid),
    .symData(symData), .cfgWrite(cfgWrite), .cfgSel(cfgSel),
    .cfgState(cfgState), .cfgData(cfgData), .reportValid(reportValid),
    .reportVec(reportVec), .reportOffset(reportOffset)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference model
  logic [ROWS-1:0]   mCol   [STATES];
  logic [STATES-1:0] mRoute [STATES];
  logic [1:0]        mStart [STATES];
  logic [STATES-1:0] mRep;
  logic [STATES-1:0] mEn;
  logic              mFirst;
  logic [OFF_W-1:0]  mNextOff;
  logic [OFF_W-1:0]  mRepOff;

  int checks = 0;
  int fails  = 0;

  function automatic logic [ROWS-1:0] oneByte(input logic [7:0] c);
    logic [ROWS-1:0] v;
    v = '0;
    v[c] = 1'b1;
    return v;
  endfunction

  function automatic logic [STATES-1:0] evalMatch(input logic [7:0] s);
    logic [STATES-1:0] cur;
    logic [STATES-1:0] m;
    for (int i = 0; i < STATES; i++)
      cur[i] = mEn[i] || (mStart[i] == 2'd2) || (mFirst && mStart[i] == 2'd1);
    for (int i = 0; i < STATES; i++) m[i] = cur[i] && mCol[i][s];
    return m;
  endfunction

  function automatic logic [STATES-1:0] evalNext(input logic [STATES-1:0] m);
    logic [STATES-1:0] n;
    n = '0;
    for (int i = 0; i < STATES; i++) if (m[i]) n |= mRoute[i];
    return n;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic check(input string tag, input logic [STATES-1:0] expV,
                       input logic [OFF_W-1:0] expO);
    checks++;
    if (reportVec !== expV || reportValid !== (expV != '0) || reportOffset !== expO) begin
      fails++;
      $display("FAIL %s: vec=%h valid=%b off=%0d expected vec=%h valid=%b off=%0d",
               tag, reportVec, reportValid, reportOffset, expV, (expV != '0), expO);
    end
  endtask

  // one clock: drive at negedge, check at following negedge
  task automatic cycle(input string tag, input logic v, input logic [7:0] s,
                       input logic sr);
    logic [STATES-1:0] m;
    logic [STATES-1:0] expV;
    expV = '0;
    symValid  = v;
    symData   = s;
    streamRst = sr;
    if (sr) begin
      mEn = '0; mFirst = 1'b1; mNextOff = '0; mRepOff = '0;
    end else if (v) begin
      m = evalMatch(s);
      expV = m & mRep;
      mEn = evalNext(m);
      mFirst = 1'b0;
      mRepOff = mNextOff;
      mNextOff = mNextOff + 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, expV, mRepOff);
    symValid  = 1'b0;
    streamRst = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] sel, input int st, input logic [ROWS-1:0] d);
    cfgWrite = 1'b1; cfgSel = sel; cfgState = SIDX_W'(st); cfgData = d;
    @(negedge clk);
    cfgWrite = 1'b0;
    case (sel)
      2'd0: mCol[st] = d;
      2'd1: mRoute[st] = d[STATES-1:0];
      2'd2: begin mStart[st] = d[1:0]; mRep[st] = d[2]; end
      default: ;
    endcase
  endtask

  task automatic feed(input string tag, input string str);
    for (int k = 0; k < str.len(); k++) cycle(tag, 1'b1, str[k], 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a17));
    rstN = 1'b0; streamRst = 1'b0; symValid = 1'b0; symData = '0;
    cfgWrite = 1'b0; cfgSel = '0; cfgState = '0; cfgData = '0;
    for (int i = 0; i < STATES; i++) begin
      mCol[i] = '0; mRoute[i] = '0; mStart[i] = 2'd0;
    end
    mRep = '0; mEn = '0; mFirst = 1'b1; mNextOff = '0; mRepOff = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset", '0, '0);

    // chain 0 -a-> 1 -b-> 2 -c-> report
    cfg(2'd0, 0, oneByte("a"));
    cfg(2'd0, 1, oneByte("b"));
    cfg(2'd0, 2, oneByte("c"));
    cfg(2'd1, 0, ROWS'(32'h2));
    cfg(2'd1, 1, ROWS'(32'h4));
    cfg(2'd2, 0, ROWS'(3'b010));   // every byte, no report
    cfg(2'd2, 2, ROWS'(3'b100));   // report only
    feed("R2 R5 chain", "xabcab");
    feed("R5 chain end", "c");
    feed("R6 silent state", "aaa");

    // start-of-data state
    cfg(2'd0, 3, oneByte("a"));
    cfg(2'd2, 3, ROWS'(3'b101));
    cycle("R8 stream reset", 1'b0, 8'h00, 1'b1);
    feed("R4 first only", "aa");
    cycle("R8 drop byte", 1'b1, "a", 1'b1);
    feed("R8 R4 rearm", "a");

    // every-byte reporting state
    cfg(2'd0, 4, oneByte("z"));
    cfg(2'd2, 4, ROWS'(3'b110));
    feed("R3 every byte", "zzxz");

    // gaps inside a pattern
    cycle("R8 reset", 1'b0, 8'h00, 1'b1);
    cycle("R11 gap", 1'b1, "a", 1'b0);
    cycle("R11 gap", 1'b0, 8'h00, 1'b0);
    cycle("R11 gap", 1'b0, 8'h00, 1'b0);
    cycle("R11 gap", 1'b1, "b", 1'b0);
    cycle("R11 gap", 1'b0, 8'h00, 1'b0);
    cycle("R11 gap", 1'b1, "c", 1'b0);

    // writes during a byte must be ignored
    cfgWrite = 1'b1; cfgSel = 2'd0; cfgState = 5'd2; cfgData = '1;
    cycle("R9 blocked column", 1'b1, "x", 1'b0);
    cfgWrite = 1'b1; cfgSel = 2'd1; cfgState = 5'd4; cfgData = ROWS'(32'h4);
    cycle("R9 blocked route", 1'b1, "x", 1'b0);
    cfgWrite = 1'b1; cfgSel = 2'd2; cfgState = 5'd2; cfgData = ROWS'(3'b110);
    cycle("R9 blocked attr", 1'b1, "x", 1'b0);
    cfgWrite = 1'b0;
    feed("R9 after blocked", "abqzqc");

    // new pattern, same routing
    cfg(2'd0, 0, oneByte("q"));
    feed("R10 reused route", "abcqbcqbq");

    // random automaton
    for (int i = 0; i < STATES; i++) begin
      logic [ROWS-1:0]   c;
      logic [STATES-1:0] r;
      for (int b = 0; b < ROWS; b++) c[b] = ($urandom % 6 == 0);
      for (int j = 0; j < STATES; j++) r[j] = ($urandom % 5 == 0);
      cfg(2'd0, i, c);
      cfg(2'd1, i, ROWS'(r));
      cfg(2'd2, i, ROWS'($urandom % 8));
    end
    cycle("R8 reset", 1'b0, 8'h00, 1'b1);
    for (int k = 0; k < 600; k++) begin
      int p;
      p = $urandom % 100;
      if (p < 4)       cycle("R8 random", $urandom % 2 == 0, 8'($urandom), 1'b1);
      else if (p < 14) cycle("R11 random", 1'b0, 8'($urandom), 1'b0);
      else             cycle("R7 random", 1'b1, 8'($urandom), 1'b0);
    end

    summary();
    $finish;
  end

endmodule